// File: doc/BRIEF.md
# Branch Target Address Rebuilder

This block turns a short run of compressed trace bytes back into a full 32-bit branch target. Each byte carries a 7-bit slice of the address plus a flag saying whether another byte follows. A run that stops early changes only the low slices it supplied. Every higher bit keeps its value from the previously rebuilt target, so short runs are cheap when a branch lands near the last one.

A run that reaches a fifth byte supplies the top four address bits and a 3-bit branch reason. From the finished address the block also works out the instruction-set mode of the processor.

A caller pulses `start_i` to open a run and then offers bytes with a valid/ready handshake. When the closing byte is taken, the address, reason, mode and full-address flag are updated together, and `done_o` pulses for one cycle.

The sequencer has three states:
- IDLE: no run is open and `pkt_ready_o` is low.
- GROUPS: taking the slice bytes.
- TAIL: waiting for the fifth byte.

It has these transitions:
- OPEN: any state goes to GROUPS on `start_i`, which also abandons a run in progress.
- NEXT: GROUPS stays in GROUPS on a byte with bit 7 set that is not the fourth.
- CLOSE_SHORT: GROUPS goes to IDLE on a byte with bit 7 clear.
- EXTEND: GROUPS goes to TAIL on a fourth byte with bit 7 set.
- CLOSE_FULL: TAIL goes to IDLE on any byte.

Top module: `branch_addr_rebuild`

## Requirements
- R1: Bytes one to four each supply 7 address bits from their bits 6:0, lowest slice first, so byte k (k from 0) fills address bits 7k+6:7k. Bit 7 of a byte set to 1 means another byte follows. A run ends on a byte with bit 7 clear, or after a fourth byte with bit 7 set (when the fifth byte ends it).
- R2: A slice that is received overwrites only its own 7 bits. All address bits not supplied in a run keep the value of the previously reported address `addr_o`.
- R3: When the fourth byte has bit 7 set, a fifth byte follows. Its bits 3:0 become address bits 31:28 and its bits 6:4 become `reason_o`. The reason codes are: 0 normal change, 1 trace enabled, 2 restart after overflow, 3 debug exit, 4 periodic sync, 5 to 7 reserved. That run reports `full_o` = 1.
- R4: A run of fewer than five bytes reports `reason_o` = 0 and `full_o` = 0.
- R5: When a full run's fifth byte has bit 7 set, `isa_o` = 2 (byte-code mode) and the address is reported unchanged.
- R6: Otherwise, if address bit 0 is 1, then `isa_o` = 1 (16-bit mode) and bit 0 is cleared. If bit 0 is 0, then `isa_o` = 0 (32-bit mode) and bits 1:0 are cleared. The cleared address becomes the base for the next run.
- R7: A fifth byte with a reason of 5, 6 or 7 sets `rsv_err_o`. The flag stays set until reset.
- R8: `start_i` opens a new run from the current `addr_o` and throws away any partly received run. `pkt_ready_o` is low while `start_i` is high and while no run is open. Bytes offered then are not taken and change nothing.
- R9: The outputs change, and `done_o` is high for exactly one cycle, only in the cycle after the closing byte is taken. At all other times the outputs hold.
- R10: Reset clears `addr_o`, `reason_o`, `full_o`, `rsv_err_o` and `done_o`, and sets `isa_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a new run |
| pkt_valid_i | input | 1 | Byte offered |
| pkt_data_i | input | 8 | Byte value |
| pkt_ready_o | output | 1 | Byte can be taken |
| addr_o | output | 32 | Rebuilt branch target |
| reason_o | output | 3 | Branch reason code |
| isa_o | output | 2 | Instruction-set mode (0 32-bit, 1 16-bit, 2 byte-code) |
| full_o | output | 1 | Last run supplied all 32 bits |
| done_o | output | 1 | One-cycle pulse when a run closes |
| rsv_err_o | output | 1 | Sticky flag for a reserved reason code |

## Verification
The bench builds the block with its default widths: four 7-bit slices and a 4-bit top field. This puts the tail byte, the byte-code mode and the reserved reasons within reach of short runs.

Runs of one, two, four and five bytes are applied over a carried-forward base address, so the keep-upper-bits rule is tested against a value that is not zero. Further runs cover a gap in `pkt_valid_i`, a run abandoned by a fresh `start_i`, bytes offered while no run is open, and a reset in the middle of the test that must clear the sticky error flag.

// File: rtl/brd_pkg.sv
`timescale 1ns/1ps
package brd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GROUPS = 2'd1,
        ST_TAIL   = 2'd2
    } brd_state_e;

    typedef enum logic [1:0] {
        ISA_WIDE     = 2'd0,
        ISA_NARROW   = 2'd1,
        ISA_BYTECODE = 2'd2
    } brd_isa_e;

    localparam int REASON_W        = 3;
    localparam int REASON_FIRST_RSV = 5;
endpackage

// File: rtl/brd_group_merge.sv
`timescale 1ns/1ps
module brd_group_merge #(
    parameter int ADDR_W = 32,
    parameter int GRP_W  = 7,
    parameter int NGRP   = 4,
    localparam int SEL_W  = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int TAIL_W = ADDR_W - NGRP * GRP_W
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [GRP_W-1:0]  slice_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              grp_en_i,
    input  logic              tail_en_i,
    output logic [ADDR_W-1:0] merged_o
);
    for (genvar g = 0; g < NGRP; g++) begin : g_slice
        assign merged_o[g*GRP_W +: GRP_W] =
            (grp_en_i && (sel_i == SEL_W'(g))) ? slice_i : base_i[g*GRP_W +: GRP_W];
    end

    assign merged_o[ADDR_W-1 -: TAIL_W] =
        tail_en_i ? slice_i[TAIL_W-1:0] : base_i[ADDR_W-1 -: TAIL_W];
endmodule

// File: rtl/brd_isa_resolve.sv
`timescale 1ns/1ps
module brd_isa_resolve
    import brd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] raw_i,
    input  logic              full_i,
    input  logic              ext_flag_i,
    output logic [ADDR_W-1:0] addr_o,
    output brd_isa_e          isa_o
);
    always_comb begin
        addr_o = raw_i;
        if (full_i && ext_flag_i) begin
            isa_o = ISA_BYTECODE;
        end else if (raw_i[0]) begin
            isa_o     = ISA_NARROW;
            addr_o[0] = 1'b0;
        end else begin
            isa_o       = ISA_WIDE;
            addr_o[1:0] = 2'b00;
        end
    end
endmodule

// File: rtl/branch_addr_rebuild.sv
`timescale 1ns/1ps
module branch_addr_rebuild
    import brd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int GRP_W  = 7,
    parameter int NGRP   = 4,
    localparam int PKT_W  = GRP_W + 1,
    localparam int SEL_W  = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int TAIL_W = ADDR_W - NGRP * GRP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                pkt_valid_i,
    input  logic [PKT_W-1:0]    pkt_data_i,
    output logic                pkt_ready_o,
    output logic [ADDR_W-1:0]   addr_o,
    output logic [REASON_W-1:0] reason_o,
    output logic [1:0]          isa_o,
    output logic                full_o,
    output logic                done_o,
    output logic                rsv_err_o
);
    brd_state_e        state_q, state_d;
    logic [SEL_W-1:0]  grp_q, grp_d;
    logic [ADDR_W-1:0] work_q;
    logic [ADDR_W-1:0] merged;
    logic [ADDR_W-1:0] clean_addr;
    brd_isa_e          isa_res;
    brd_isa_e          isa_q;
    logic              take, more, last_grp;
    logic              close_short, close_full, close_any;
    logic [REASON_W-1:0] tail_reason;

    assign pkt_ready_o = (state_q != ST_IDLE) && !start_i;
    assign take        = pkt_valid_i && pkt_ready_o;
    assign more        = pkt_data_i[PKT_W-1];
    assign last_grp    = (grp_q == SEL_W'(NGRP - 1));
    assign close_short = take && (state_q == ST_GROUPS) && !more;
    assign close_full  = take && (state_q == ST_TAIL);
    assign close_any   = close_short || close_full;
    assign tail_reason = pkt_data_i[TAIL_W +: REASON_W];

    brd_group_merge #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .NGRP(NGRP)) merge_i (
        .base_i    (work_q),
        .slice_i   (pkt_data_i[GRP_W-1:0]),
        .sel_i     (grp_q),
        .grp_en_i  (state_q == ST_GROUPS),
        .tail_en_i (state_q == ST_TAIL),
        .merged_o  (merged)
    );

    brd_isa_resolve #(.ADDR_W(ADDR_W)) resolve_i (
        .raw_i      (merged),
        .full_i     (close_full),
        .ext_flag_i (more),
        .addr_o     (clean_addr),
        .isa_o      (isa_res)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        grp_d   = grp_q;
        if (start_i) begin
            state_d = ST_GROUPS;
            grp_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_GROUPS: if (take) begin
                    if (!more)         state_d = ST_IDLE;
                    else if (last_grp) state_d = ST_TAIL;
                    else               grp_d   = grp_q + 1'b1;
                end
                ST_TAIL: if (take) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register and working address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grp_q   <= '0;
            work_q  <= '0;
        end else begin
            state_q <= state_d;
            grp_q   <= grp_d;
            if (start_i)   work_q <= addr_o;
            else if (take) work_q <= merged;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o    <= '0;
            reason_o  <= '0;
            isa_q     <= ISA_WIDE;
            full_o    <= 1'b0;
            done_o    <= 1'b0;
            rsv_err_o <= 1'b0;
        end else begin
            done_o <= close_any;
            if (close_any) begin
                addr_o   <= clean_addr;
                isa_q    <= isa_res;
                full_o   <= close_full;
                reason_o <= close_full ? tail_reason : '0;
            end
            if (close_full && (tail_reason >= REASON_W'(REASON_FIRST_RSV)))
                rsv_err_o <= 1'b1;
        end
    end

    assign isa_o = isa_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(addr_o) && $stable(isa_o) && $stable(full_o) && $stable(reason_o)));
    // R4
    short_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !full_o) |-> (reason_o == '0 && isa_o != ISA_BYTECODE));
    // R6
    narrow_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && isa_o == ISA_NARROW) |-> !addr_o[0]);
    // R6
    wide_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && isa_o == ISA_WIDE) |-> (addr_o[1:0] == 2'b00));
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_err_o |=> rsv_err_o);
    // R8
    idle_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |-> !pkt_ready_o);
endmodule

// File: tb/branch_addr_rebuild_tb.sv
`timescale 1ns/1ps
module branch_addr_rebuild_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        pkt_valid_i = 1'b0;
    logic [7:0]  pkt_data_i = 8'h00;
    logic        pkt_ready_o;
    logic [31:0] addr_o;
    logic [2:0]  reason_o;
    logic [1:0]  isa_o;
    logic        full_o, done_o, rsv_err_o;

    always #2 clk = ~clk;

    branch_addr_rebuild dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .pkt_valid_i(pkt_valid_i), .pkt_data_i(pkt_data_i), .pkt_ready_o(pkt_ready_o),
        .addr_o(addr_o), .reason_o(reason_o), .isa_o(isa_o),
        .full_o(full_o), .done_o(done_o), .rsv_err_o(rsv_err_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    logic [31:0] e_addr = '0;
    logic [2:0]  e_reason = '0;
    logic [1:0]  e_isa = '0;
    logic        e_full = 1'b0, e_done = 1'b0, e_err = 1'b0;
    logic [7:0]  seq_q[$];

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the rising edge
    always @(negedge clk) if (chk_en) begin
        chk("R1/R2 addr_o", addr_o, e_addr);
        chk("R3/R4 reason_o", 32'(reason_o), 32'(e_reason));
        chk("R3/R4 full_o", 32'(full_o), 32'(e_full));
        chk("R5/R6 isa_o", 32'(isa_o), 32'(e_isa));
        chk("R7 rsv_err_o", 32'(rsv_err_o), 32'(e_err));
        chk("R9 done_o", 32'(done_o), 32'(e_done));
    end

    task automatic model_close();
        logic [31:0] w;
        logic [7:0]  t;
        int n;
        w = e_addr;
        n = seq_q.size();
        t = 8'h00;
        for (int i = 0; i < n && i < 4; i++) w[7*i +: 7] = seq_q[i][6:0];
        if (n == 5) begin
            t = seq_q[4];
            w[31:28] = t[3:0];
            e_reason = t[6:4];
            e_full   = 1'b1;
            if (t[6:4] >= 3'd5) e_err = 1'b1;
        end else begin
            e_reason = 3'd0;
            e_full   = 1'b0;
        end
        if (n == 5 && t[7]) e_isa = 2'd2;
        else if (w[0]) begin e_isa = 2'd1; w[0] = 1'b0; end
        else begin e_isa = 2'd0; w[1:0] = 2'b00; end
        e_addr = w;
    endtask

    task automatic open_run();
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
    endtask

    // Drive the whole of seq_q; gap_at inserts one idle cycle before that byte
    task automatic run_seq(input int gap_at);
        open_run();
        foreach (seq_q[i]) begin
            if (i == gap_at) begin
                pkt_valid_i = 1'b0;
                @(posedge clk); #1;
            end
            pkt_valid_i = 1'b1;
            pkt_data_i  = seq_q[i];
            @(posedge clk); #1;
        end
        pkt_valid_i = 1'b0;
        model_close();
        e_done = 1'b1;
        @(posedge clk); #1 e_done = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        chk_en = 1'b0;
        rst_n  = 1'b0;
        e_addr = '0; e_reason = '0; e_isa = '0;
        e_full = 1'b0; e_done = 1'b0; e_err = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset addr_o", addr_o, 32'h0);
        chk("R10 reset isa_o", 32'(isa_o), 32'h0);
        chk("R10 reset flags", {full_o, done_o, rsv_err_o, reason_o}, 32'h0);
        chk_en = 1'b1;
    endtask

    initial begin
        do_reset();

        // R8: bytes offered with no open run are refused and change nothing
        @(posedge clk); #1;
        pkt_valid_i = 1'b1; pkt_data_i = 8'h15;
        repeat (3) @(posedge clk);
        #1 chk("R8 ready low while idle", 32'(pkt_ready_o), 32'h0);
        pkt_valid_i = 1'b0;
        @(posedge clk); #1 chk("R8 idle bytes ignored", addr_o, 32'h0);

        // R1/R6: one byte, odd low bit
        seq_q = '{8'h15}; run_seq(-1);
        // R1/R2: two bytes, even
        seq_q = '{8'hFC, 8'h03}; run_seq(-1);
        // R3/R6: full run, reason 2, narrow mode
        seq_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h2A}; run_seq(-1);
        #1 chk("R3 full addr", addr_o, 32'hAFFFFFFE);
        // R2/R4: short run over nonzero base
        seq_q = '{8'h04}; run_seq(-1);
        #1 chk("R2 upper bits kept", addr_o, 32'hAFFFFF84);
        // R5: byte-code mode, reason 4
        seq_q = '{8'h81, 8'h80, 8'h80, 8'h80, 8'hC3}; run_seq(-1);
        #1 chk("R5 bytecode addr", addr_o, 32'h30000001);
        // R4: four bytes, last ends the run
        seq_q = '{8'h80, 8'h80, 8'h80, 8'h11}; run_seq(-1);
        // R9: gap in valid mid-run
        seq_q = '{8'h9B, 8'h8C, 8'h22}; run_seq(2);
        // R8: abandoned partial run, then a fresh one
        open_run();
        pkt_valid_i = 1'b1; pkt_data_i = 8'hEE; @(posedge clk); #1;
        pkt_data_i = 8'hDD; @(posedge clk); #1;
        pkt_valid_i = 1'b0;
        seq_q = '{8'h40}; run_seq(-1);
        // R7: reserved reason sets sticky flag
        seq_q = '{8'h80, 8'h80, 8'h80, 8'h80, 8'h5F}; run_seq(-1);
        seq_q = '{8'h02}; run_seq(-1);
        #1 chk("R7 flag sticky", 32'(rsv_err_o), 32'h1);
        // R10: reset clears the flag
        do_reset();
        seq_q = '{8'h80, 8'h80, 8'h80, 8'h80, 8'h07}; run_seq(-1);
        repeat (3) @(posedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule